// File: doc/BRIEF.md
# Flash Block Bad-Marker Scanner

The scanner decides whether one erase block of a raw flash array carries a factory bad-block mark. A start pulse hands it a block number, the number of pages per block, the length of the spare area and a policy. It then asks for the spare area of at most two pages of that block. For each request it raises a one-cycle fetch strobe with the page number on it. An external reader, which is not part of this block, streams the spare bytes back one per cycle. The scanner inspects each byte as it arrives and stops at the first bad indication. When it stops it pulses `done` and holds one of three results: good, bad, or read error.

Two policies are supported. The first-byte policy looks only at spare byte 0 of the block's first page and of the page after it. The whole-spare policy looks at every spare byte of the block's first page and of its last page. A zero byte found where the active policy looks marks the block bad. The reader may also signal a read error at any time while a scan runs. A read error ends the scan with an error flag and no verdict.

Top module: `bad_block_scan`

## Requirements
- R1: A `start` pulse sampled while idle begins a scan: `busy` is 1 from the next cycle, and `is_bad` and `scan_err` are cleared. While `busy` is 1, `start` is ignored, and the page being fetched does not change without a spare byte.
- R2: The first fetch is a one-cycle `fetch_vld` pulse in the cycle after the accepted `start`. Its `fetch_page` equals `block_num * pages_per_blk`.
- R3: With `scan_whole` = 0 (first-byte policy), the second page fetched is the first page + 1. Only the byte at index 0 of each page's spare stream is judged: a value of 0x00 there marks the block bad. Zero bytes at other indices have no effect.
- R4: With `scan_whole` = 1 (whole-spare policy), the second page fetched is the first page + `pages_per_blk` − 1. A 0x00 at any index from 0 to `spare_len` − 1 marks the block bad.
- R5: On the cycle after a bad byte is accepted, `done` pulses for one cycle with `is_bad` = 1 and `busy` = 0. No further fetch is issued, and the remaining bytes of that page are ignored.
- R6: When the byte at index `spare_len` − 1 of the second page is accepted without a bad indication, `done` pulses on the next cycle with `is_bad` = 0 and `scan_err` = 0. `spare_len` must be at least 1.
- R7: `rd_err` while busy ends the scan on the next cycle with `done` pulsed, `scan_err` = 1 and `is_bad` = 0. It takes priority over a byte accepted in the same cycle. `is_bad` and `scan_err` are never both 1.
- R8: `is_bad` and `scan_err` hold their values until the next accepted `start`. `byte_vld` and `rd_err` have no effect while idle.
- R9: When the last byte (index `spare_len` − 1) of the first page is accepted without a bad indication, the second fetch pulses on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (accepted only while idle) |
| scan_whole | input | 1 | 0: first-byte policy, 1: whole-spare policy |
| block_num | input | BLK_W | Block to scan |
| pages_per_blk | input | PPB_W | Pages in one block |
| spare_len | input | SPR_W | Spare bytes per page (at least 1) |
| rd_err | input | 1 | Reader reports a failed read |
| byte_vld | input | 1 | A spare byte is present on byte_dat |
| byte_dat | input | DATA_W | Spare byte value |
| fetch_vld | output | 1 | One-cycle request for a page's spare area |
| fetch_page | output | BLK_W+PPB_W | Page number of the request |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| is_bad | output | 1 | Verdict: block marked bad |
| scan_err | output | 1 | Scan ended by a read error |

## Verification
Two endings of a scan can fall in one cycle: a read error, and a decisive byte. The decisive byte is either a zero byte where the policy looks or the last byte of the second page. The bench provokes the clash by raising `rd_err` in the same cycle as a zero byte, and also in the same cycle as the final byte of a clean second page. Both cases are judged by `scan_err` = 1 with `is_bad` = 0, checked cycle by cycle against the behavioural model. A `start` sent while a scan is still running is a second overlap. It is judged by the fetched page numbers, which must stay those of the first block.

// File: rtl/bbscan_pkg.sv
package bbscan_pkg;
  typedef enum logic {
    POL_FIRST_BYTE  = 1'b0,
    POL_WHOLE_SPARE = 1'b1
  } scan_pol_e;

  typedef enum logic {
    PG_FIRST  = 1'b0,
    PG_SECOND = 1'b1
  } page_sel_e;
endpackage

// File: rtl/bbscan_page_gen.sv
module bbscan_page_gen
  import bbscan_pkg::*;
#(
  parameter int BLK_W  = 12,
  parameter int PPB_W  = 9,
  parameter int PAGE_W = BLK_W + PPB_W
) (
  input  logic [BLK_W-1:0]  blk,
  input  logic [PPB_W-1:0]  ppb,
  input  scan_pol_e         pol,
  input  page_sel_e         sel,
  output logic [PAGE_W-1:0] page
);
  logic [PAGE_W-1:0] base;
  logic [PAGE_W-1:0] offs;

  always_comb begin
    base = PAGE_W'(blk) * PAGE_W'(ppb);
    if (sel == PG_FIRST)
      offs = '0;
    else if (pol == POL_WHOLE_SPARE)
      offs = PAGE_W'(ppb) - PAGE_W'(1);
    else
      offs = PAGE_W'(1);
    page = base + offs;
  end
endmodule

// File: rtl/bbscan_byte_judge.sv
module bbscan_byte_judge
  import bbscan_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] dat,
  input  scan_pol_e         pol,
  input  logic              at_first,
  output logic              hit
);
  logic in_window;

  always_comb begin
    in_window = (pol == POL_WHOLE_SPARE) || at_first;
    hit       = in_window && (dat == '0);
  end
endmodule

// File: rtl/bad_block_scan.sv
module bad_block_scan
  import bbscan_pkg::*;
#(
  parameter int BLK_W  = 12,
  parameter int PPB_W  = 9,
  parameter int SPR_W  = 11,
  parameter int DATA_W = 8,
  localparam int PAGE_W = BLK_W + PPB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              scan_whole,
  input  logic [BLK_W-1:0]  block_num,
  input  logic [PPB_W-1:0]  pages_per_blk,
  input  logic [SPR_W-1:0]  spare_len,
  input  logic              rd_err,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_dat,
  output logic              fetch_vld,
  output logic [PAGE_W-1:0] fetch_page,
  output logic              busy,
  output logic              done,
  output logic              is_bad,
  output logic              scan_err
);
  scan_pol_e          lat_pol;
  logic [BLK_W-1:0]   lat_blk;
  logic [PPB_W-1:0]   lat_ppb;
  logic [SPR_W-1:0]   lat_spr;
  page_sel_e          sel_q;
  logic [SPR_W-1:0]   cnt_q;

  logic               busy_q, done_q, bad_q, err_q, fv_q;
  logic [PAGE_W-1:0]  page_q;

  logic [PAGE_W-1:0]  first_page, second_page;
  logic               hit, last_byte;
  scan_pol_e          in_pol;

  assign in_pol    = scan_pol_e'(scan_whole);
  assign last_byte = (cnt_q == (lat_spr - SPR_W'(1)));

  bbscan_page_gen #(.BLK_W(BLK_W), .PPB_W(PPB_W), .PAGE_W(PAGE_W)) u_first (
    .blk (block_num),
    .ppb (pages_per_blk),
    .pol (in_pol),
    .sel (PG_FIRST),
    .page(first_page)
  );

  bbscan_page_gen #(.BLK_W(BLK_W), .PPB_W(PPB_W), .PAGE_W(PAGE_W)) u_second (
    .blk (lat_blk),
    .ppb (lat_ppb),
    .pol (lat_pol),
    .sel (PG_SECOND),
    .page(second_page)
  );

  bbscan_byte_judge #(.DATA_W(DATA_W)) u_judge (
    .dat     (byte_dat),
    .pol     (lat_pol),
    .at_first(cnt_q == '0),
    .hit     (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      bad_q   <= 1'b0;
      err_q   <= 1'b0;
      fv_q    <= 1'b0;
      page_q  <= '0;
      sel_q   <= PG_FIRST;
      cnt_q   <= '0;
      lat_pol <= POL_FIRST_BYTE;
      lat_blk <= '0;
      lat_ppb <= '0;
      lat_spr <= '0;
    end else begin
      done_q <= 1'b0;
      fv_q   <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          bad_q   <= 1'b0;
          err_q   <= 1'b0;
          fv_q    <= 1'b1;
          page_q  <= first_page;
          sel_q   <= PG_FIRST;
          cnt_q   <= '0;
          lat_pol <= in_pol;
          lat_blk <= block_num;
          lat_ppb <= pages_per_blk;
          lat_spr <= spare_len;
        end
      end else if (rd_err) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        err_q  <= 1'b1;
      end else if (byte_vld) begin
        if (hit) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          bad_q  <= 1'b1;
        end else if (last_byte) begin
          if (sel_q == PG_FIRST) begin
            sel_q  <= PG_SECOND;
            cnt_q  <= '0;
            fv_q   <= 1'b1;
            page_q <= second_page;
          end else begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + SPR_W'(1);
        end
      end
    end
  end

  assign fetch_vld  = fv_q;
  assign fetch_page = page_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign is_bad     = bad_q;
  assign scan_err   = err_q;

  AST_FETCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    fetch_vld |-> busy); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(is_bad && scan_err)); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(is_bad) && $stable(scan_err))); // R8
  AST_NO_STRAY_FETCH: assert property (@(posedge clk) disable iff (rst)
    (busy && !byte_vld && !rd_err) |=> (busy && $stable(fetch_page) && !fetch_vld)); // R1
  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_err) |=> (done && scan_err)); // R7
endmodule

// File: tb/bad_block_scan_test.sv
module bad_block_scan_test;
  localparam int BLK_W = 12, PPB_W = 9, SPR_W = 11, DATA_W = 8;
  localparam int PAGE_W = BLK_W + PPB_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              scan_whole = 1'b0;
  logic [BLK_W-1:0]  block_num = '0;
  logic [PPB_W-1:0]  pages_per_blk = '0;
  logic [SPR_W-1:0]  spare_len = '0;
  logic              rd_err = 1'b0;
  logic              byte_vld = 1'b0;
  logic [DATA_W-1:0] byte_dat = '0;
  logic              fetch_vld, busy, done, is_bad, scan_err;
  logic [PAGE_W-1:0] fetch_page;

  bad_block_scan #(.BLK_W(BLK_W), .PPB_W(PPB_W), .SPR_W(SPR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .start(start), .scan_whole(scan_whole),
    .block_num(block_num), .pages_per_blk(pages_per_blk), .spare_len(spare_len),
    .rd_err(rd_err), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .fetch_vld(fetch_vld), .fetch_page(fetch_page), .busy(busy), .done(done),
    .is_bad(is_bad), .scan_err(scan_err)
  );

  int vecs = 0, errs = 0, cycles = 0;
  bit armed = 0;
  int fq[$];

  // behavioural reference state
  int m_busy = 0, m_sel = 0, m_cnt = 0, m_pol = 0, m_spr = 0, m_base = 0, m_ppb = 0;
  int e_busy = 0, e_done = 0, e_bad = 0, e_err = 0, e_fv = 0, e_pg = 0;

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_sel = 0; m_cnt = 0;
      e_busy = 0; e_done = 0; e_bad = 0; e_err = 0; e_fv = 0; e_pg = 0;
    end else begin
      e_done = 0; e_fv = 0;
      if (m_busy == 0) begin
        if (start) begin
          m_busy = 1; e_busy = 1; e_bad = 0; e_err = 0;
          m_pol = int'(scan_whole); m_ppb = int'(pages_per_blk);
          m_spr = int'(spare_len);
          m_base = int'(block_num) * int'(pages_per_blk);
          m_sel = 0; m_cnt = 0; e_fv = 1; e_pg = m_base;
        end
      end else if (rd_err) begin
        m_busy = 0; e_busy = 0; e_done = 1; e_err = 1;
      end else if (byte_vld) begin
        if (byte_dat == 0 && (m_pol == 1 || m_cnt == 0)) begin
          m_busy = 0; e_busy = 0; e_done = 1; e_bad = 1;
        end else if (m_cnt == m_spr - 1) begin
          if (m_sel == 0) begin
            m_sel = 1; m_cnt = 0; e_fv = 1;
            e_pg = (m_pol == 1) ? m_base + m_ppb - 1 : m_base + 1;
          end else begin
            m_busy = 0; e_busy = 0; e_done = 1;
          end
        end else begin
          m_cnt++;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (armed) begin
      chk("R1 busy", int'(busy), e_busy);
      chk("R6 done", int'(done), e_done);
      chk("R5 is_bad", int'(is_bad), e_bad);
      chk("R7 scan_err", int'(scan_err), e_err);
      chk("R9 fetch_vld", int'(fetch_vld), e_fv);
      if (fetch_vld) begin
        chk("R2 fetch_page", int'(fetch_page), e_pg);
        fq.push_back(int'(fetch_page));
      end
    end
    if (cycles > 100000) begin
      errs++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      wrap_up();
    end
  end

  task automatic begin_scan(input int pol, input int blk, input int ppb, input int spr);
    fq.delete();
    scan_whole = pol[0]; block_num = BLK_W'(blk);
    pages_per_blk = PPB_W'(ppb); spare_len = SPR_W'(spr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // n bytes; zero at index zi; read error at index ei (-1 for none)
  task automatic feed(input int n, input int zi, input int ei);
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b1;
      byte_dat = (i == zi) ? 8'h00 : DATA_W'(i | 1);
      rd_err   = (i == ei);
      @(negedge clk);
    end
    byte_vld = 1'b0; rd_err = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    armed = 1;
    chk("R1 reset busy", int'(busy), 0);
    chk("R8 reset is_bad", int'(is_bad), 0);
    rst = 1'b0;
    @(negedge clk);

    // first-byte policy, clean block
    begin_scan(0, 5, 64, 16);
    feed(16, -1, -1); feed(16, -1, -1); settle();
    chk("R6 good verdict", int'(is_bad), 0);
    chk("R3 fetch count", fq.size(), 2);
    chk("R2 first page", fq[0], 320);
    chk("R3 second page", fq[1], 321);

    // first-byte policy, zero at byte 0 of first page
    begin_scan(0, 7, 64, 16);
    feed(16, 0, -1); settle();
    chk("R5 bad verdict", int'(is_bad), 1);
    chk("R5 single fetch", fq.size(), 1);

    // first-byte policy, zeros away from byte 0 are ignored
    begin_scan(0, 2, 32, 8);
    feed(8, 3, -1); feed(8, 7, -1); settle();
    chk("R3 non-first zero ignored", int'(is_bad), 0);

    // first-byte policy, zero at byte 0 of second page
    begin_scan(0, 9, 16, 4);
    feed(4, -1, -1); feed(4, 0, -1); settle();
    chk("R3 second page bad", int'(is_bad), 1);

    // whole-spare policy, clean block
    begin_scan(1, 3, 32, 8);
    feed(8, -1, -1); feed(8, -1, -1); settle();
    chk("R4 good verdict", int'(is_bad), 0);
    chk("R4 last page", fq[1], 127);

    // whole-spare policy, zero mid-spare of last page, trailing bytes ignored
    begin_scan(1, 4, 32, 8);
    feed(8, -1, -1); feed(8, 5, -1); settle();
    chk("R4 any-byte zero", int'(is_bad), 1);
    chk("R5 no third fetch", fq.size(), 2);

    // idle: bytes and errors have no effect
    feed(6, 0, 2);
    chk("R8 idle hold bad", int'(is_bad), 1);
    chk("R8 idle no err", int'(scan_err), 0);

    // read error mid second page
    begin_scan(1, 1, 8, 6);
    feed(6, -1, -1); feed(6, -1, 2); settle();
    chk("R7 error flag", int'(scan_err), 1);
    chk("R7 no verdict", int'(is_bad), 0);

    // read error with a zero byte in the same cycle
    begin_scan(1, 6, 8, 6);
    feed(6, 1, 1); settle();
    chk("R7 error beats zero", int'(scan_err), 1);

    // read error with the final clean byte in the same cycle
    begin_scan(0, 6, 8, 3);
    feed(3, -1, -1); feed(3, -1, 2); settle();
    chk("R7 error beats last byte", int'(scan_err), 1);

    // start while busy is ignored; minimum spare length
    begin_scan(0, 10, 4, 1);
    scan_whole = 1'b1; block_num = 12'd99; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    feed(1, -1, -1); feed(1, -1, -1); settle();
    chk("R1 start ignored page", fq[0], 40);
    chk("R1 start ignored second", fq[1], 41);
    chk("R9 two fetches", fq.size(), 2);

    wrap_up();
  end
endmodule